// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sets the pace for a successive-approximation converter that has up to four sample-and-hold (S/H) channels. A programmable divider turns the system clock into a converter-clock tick. The sequencer times a sample window that is a whole number of those ticks. It then issues a one-cycle convert-start strobe and waits for the converter to report that it has finished. When auto-sampling is on, the next window opens in the same cycle that the done indication arrives.

With two or more S/H channels enabled, the block walks through them in turn. The channel being converted holds its sample, and every other enabled channel keeps acquiring. This hides most of the acquisition time behind the conversion. A conversion counter raises a single-cycle interrupt after a programmed number of conversions and then returns the channel pointer to channel 0.

The configuration fields are captured at the start of each sample window, so they can be rewritten while the block runs. Clearing the enable input stops the block at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with the block disabled, samp_en_o is 0, conv_start_o is 0, irq_o is 0 and chan_sel_o is 0.
- R2: A sample window lasts max(samp_time_i,1)*(clk_div_i+1) system clock cycles. The convert-start strobe is high in the cycle right after the window.
- R3: Only trig_sel_i = 3'b111 ends a window automatically. With any other value, sampling of the current channel continues and conv_start_o never rises.
- R4: With auto_samp_i = 1, a new window begins in the cycle after conv_done_i is accepted. With auto_samp_i = 0, the block goes idle after a conversion and starts a window only on a samp_start_i pulse.
- R5: chan_cnt_i selects the number of active channels: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4. chan_sel_o steps 0,1,…,n-1 and then wraps to 0, advancing once per completed conversion.
- R6: During a window, samp_en_o is high for every active channel. During a conversion, samp_en_o is high for every active channel except the one on chan_sel_o.
- R7: irq_o is high for exactly one cycle, in the cycle after the (conv_lim_i+1)-th accepted conv_done_i. In that same cycle chan_sel_o is 0, and the conversion count starts again from zero.
- R8: In the cycle after en_i is sampled low, samp_en_o, conv_start_o, irq_o and chan_sel_o are all 0. The next enable starts a fresh conversion count at channel 0.
- R9: Changes to samp_time_i, clk_div_i, chan_cnt_i, conv_lim_i and trig_sel_i made during a window take effect only at the next window.
- R10: conv_start_o is never high in two consecutive cycles. A conv_done_i pulse while no conversion is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| trig_sel_i | input | 3 | Window-end source; 3'b111 selects automatic |
| auto_samp_i | input | 1 | Reopen a window automatically after each conversion |
| samp_start_i | input | 1 | One-cycle request to open a window |
| samp_time_i | input | 5 | Window length in converter-clock ticks |
| clk_div_i | input | 6 | Converter clock = (clk_div_i+1) system cycles |
| chan_cnt_i | input | 2 | Active S/H channel count code |
| conv_lim_i | input | 4 | Conversions between interrupts, minus one |
| conv_done_i | input | 1 | Converter has finished the current conversion |
| samp_en_o | output | 4 | Per-channel acquire enable |
| conv_start_o | output | 1 | One-cycle convert-start strobe |
| chan_sel_o | output | 2 | Channel being sampled or converted |
| irq_o | output | 1 | Conversion-batch interrupt pulse |

## Verification
A corrupted tick divider or window counter shows up as a convert-start strobe that arrives early or late. This is visible by the end of the first window after enable. A pointer that slips or wraps at the wrong bound shows as a wrong chan_sel_o or a wrong acquire mask at the next convert-start. A conversion counter with the wrong limit moves or drops the interrupt within one batch. A stale configuration capture shows as a window of the wrong length on the first or second window after a field change.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SH_NUM = 4;
  localparam int SEL_W  = $clog2(SH_NUM);

  localparam logic [2:0] TRIG_AUTO = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

  // Index of the highest active S/H channel for a channel-count code
  function automatic logic [SEL_W-1:0] last_idx(input logic [1:0] code);
    case (code)
      2'b00:   last_idx = SEL_W'(0);
      2'b01:   last_idx = SEL_W'(1);
      default: last_idx = SEL_W'(SH_NUM - 1);
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_no = ff2_q;
endmodule

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == div_i);
    if (!run_i || clr_i || tick_o) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_count.sv
module adc_seq_count
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             done_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] last_cur_i,
  input  logic [SEL_W-1:0] last_new_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [SEL_W-1:0] ptr_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] ptr_q, ptr_d, ptr_adv;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d   = cnt_q;
    ptr_adv = ptr_q;
    irq_d   = 1'b0;
    if (done_i) begin
      if (cnt_q == lim_i) begin
        cnt_d   = '0;
        ptr_adv = '0;
        irq_d   = 1'b1;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        ptr_adv = (ptr_q == last_cur_i) ? '0 : ptr_q + 1'b1;
      end
    end
    ptr_d = (load_i && (ptr_adv > last_new_i)) ? '0 : ptr_adv;
    if (!en_i) begin
      cnt_d = '0;
      ptr_d = '0;
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
      irq_q <= irq_d;
    end
  end

  assign ptr_o = ptr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int ST_W  = 5,
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        trig_sel_i,
  input  logic              auto_samp_i,
  input  logic              samp_start_i,
  input  logic [ST_W-1:0]   samp_time_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [1:0]        chan_cnt_i,
  input  logic [CNT_W-1:0]  conv_lim_i,
  input  logic              conv_done_i,
  output logic [SH_NUM-1:0] samp_en_o,
  output logic              conv_start_o,
  output logic [SEL_W-1:0]  chan_sel_o,
  output logic              irq_o
);
  logic rst_n;

  seq_state_e       state_q, state_d;
  logic [ST_W-1:0]  win_q, win_d;
  logic [ST_W-1:0]  st_q, st_eff;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] last_q, last_new;
  logic [CNT_W-1:0] lim_q;
  logic [2:0]       trig_q;
  logic             cs_q, cs_d;
  logic             tick, start_win, end_win, done_evt, run;
  logic [SEL_W-1:0] ptr;
  logic [SH_NUM-1:0] act;

  adc_seq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign run      = (state_q != ST_IDLE);
  assign last_new = last_idx(chan_cnt_i);
  assign st_eff   = (st_q == '0) ? ST_W'(1) : st_q;
  assign done_evt = en_i && (state_q == ST_CONVERT) && conv_done_i;
  assign start_win = en_i && (((state_q == ST_IDLE) && (auto_samp_i || samp_start_i)) ||
                              (done_evt && auto_samp_i));
  assign end_win  = en_i && (state_q == ST_SAMPLE) && tick &&
                    (trig_q == TRIG_AUTO) && (win_q == st_eff - ST_W'(1));

  adc_seq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run && en_i),
    .clr_i  (start_win),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_seq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (en_i),
    .done_i     (done_evt),
    .load_i     (start_win),
    .last_cur_i (last_q),
    .last_new_i (last_new),
    .lim_i      (lim_q),
    .ptr_o      (ptr),
    .irq_o      (irq_o)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    cs_d    = end_win;
    unique case (state_q)
      ST_IDLE:    if (start_win) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (end_win)   state_d = ST_CONVERT;
        else if (tick) win_d   = win_q + 1'b1;
      end
      ST_CONVERT: if (done_evt) state_d = auto_samp_i ? ST_SAMPLE : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (start_win) win_d = '0;
    if (!en_i) begin
      state_d = ST_IDLE;
      win_d   = '0;
      cs_d    = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      cs_q    <= cs_d;
    end
  end

  // Configuration captured at each window start
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      div_q  <= '0;
      last_q <= '0;
      lim_q  <= '0;
      trig_q <= '0;
    end else if (start_win) begin
      st_q   <= samp_time_i;
      div_q  <= clk_div_i;
      last_q <= last_new;
      lim_q  <= conv_lim_i;
      trig_q <= trig_sel_i;
    end
  end

  for (genvar g = 0; g < SH_NUM; g++) begin : g_sh
    assign act[g]       = (SEL_W'(g) <= last_q);
    assign samp_en_o[g] = act[g] && ((state_q == ST_SAMPLE) ||
                                     ((state_q == ST_CONVERT) && (ptr != SEL_W'(g))));
  end

  assign conv_start_o = cs_q;
  assign chan_sel_o   = ptr;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [SH_NUM-1:0] samp_en_o,
  input logic              conv_start_o,
  input logic [SEL_W-1:0]  chan_sel_o,
  input logic              irq_o
);
  AST_CONV_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R10

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7

  AST_IRQ_PTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chan_sel_o == '0)); // R7

  AST_CONV_CH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !samp_en_o[chan_sel_o]); // R6

  AST_DISABLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (samp_en_o == '0 && !conv_start_o && !irq_o && chan_sel_o == '0)); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .samp_en_o    (samp_en_o),
  .conv_start_o (conv_start_o),
  .chan_sel_o   (chan_sel_o),
  .irq_o        (irq_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // vector: {div, samp_time, chan code, limit}
  localparam logic [5:0] V_DIV [NV] = '{6'd1, 6'd0, 6'd2, 6'd3};
  localparam logic [4:0] V_ST  [NV] = '{5'd2, 5'd3, 5'd2, 5'd0};
  localparam logic [1:0] V_CC  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [3:0] V_LIM [NV] = '{4'd0, 4'd1, 4'd5, 4'd2};

  logic clk = 1'b0;
  logic rst_n, en, auto_s, s_start, c_done;
  logic [2:0] trig;
  logic [4:0] st;
  logic [5:0] dv;
  logic [1:0] cc;
  logic [3:0] lim;
  logic [3:0] samp_en;
  logic conv_start, irq;
  logic [1:0] sel;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .trig_sel_i(trig),
    .auto_samp_i(auto_s), .samp_start_i(s_start), .samp_time_i(st),
    .clk_div_i(dv), .chan_cnt_i(cc), .conv_lim_i(lim), .conv_done_i(c_done),
    .samp_en_o(samp_en), .conv_start_o(conv_start), .chan_sel_o(sel), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int win_len(input int s, input int d);
    return ((s == 0) ? 1 : s) * (d + 1);
  endfunction

  function automatic int nch_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic wait_cs(output int n);
    n = 0;
    while (!conv_start && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // at a convert-start negedge: check channel and mask, then finish conversion
  task automatic do_conv(input int eptr, input int emask, input int eirq, input string tag);
    check({tag, " R5 chan_sel at convert"}, sel, eptr);
    check({tag, " R6 samp_en during convert"}, samp_en, emask);
    @(negedge clk);
    check({tag, " R10 convert strobe width"}, conv_start, 0);
    @(negedge clk);
    c_done = 1'b1;
    @(negedge clk);
    c_done = 1'b0;
    check({tag, " R7 irq after done"}, irq, eirq);
    if (eirq != 0) check({tag, " R7 pointer back to 0"}, sel, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; en = 1'b0; trig = 3'b111; auto_s = 1'b1; s_start = 1'b0;
    c_done = 1'b0; st = 5'd2; dv = 6'd1; cc = 2'd0; lim = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 reset samp_en", samp_en, 0);
    check("R1 reset conv_start", conv_start, 0);
    check("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 released, disabled samp_en", samp_en, 0);
    check("R1 released, disabled chan_sel", sel, 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      int nch, amask;
      en = 1'b0; @(negedge clk);
      dv = V_DIV[v]; st = V_ST[v]; cc = V_CC[v]; lim = V_LIM[v];
      trig = 3'b111; auto_s = 1'b1; en = 1'b1;
      @(negedge clk);
      nch = nch_of(V_CC[v]);
      amask = (1 << nch) - 1;
      for (int k = 0; k <= int'(V_LIM[v]); k++) begin
        int p;
        p = k % nch;
        check($sformatf("v%0d R6 samp_en during window", v), samp_en, amask);
        wait_cs(n);
        check($sformatf("v%0d R2 window length", v), n, win_len(V_ST[v], V_DIV[v]));
        do_conv(p, amask & ~(1 << p), (k == int'(V_LIM[v])) ? 1 : 0, $sformatf("v%0d", v));
      end
    end

    // R3: trigger field other than 3'b111 never converts
    en = 1'b0; @(negedge clk);
    trig = 3'b000; st = 5'd1; dv = 6'd0; cc = 2'd0; lim = 4'd0; en = 1'b1;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (conv_start) n++;
    end
    check("R3 no convert with manual trigger", n, 0);
    check("R3 channel 0 keeps sampling", samp_en, 1);

    // R4: no auto-sample waits for a start pulse, then idles again
    en = 1'b0; @(negedge clk);
    trig = 3'b111; auto_s = 1'b0; st = 5'd2; dv = 6'd1; en = 1'b1;
    repeat (10) @(negedge clk);
    check("R4 idle without start pulse", samp_en, 0);
    s_start = 1'b1; @(negedge clk); s_start = 1'b0;
    check("R4 window opened by start pulse", samp_en, 1);
    wait_cs(n);
    check("R4 window length after start pulse", n, 4);
    do_conv(0, 0, 1, "manual");
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (conv_start || samp_en != 0) n++;
    end
    check("R4 idle after conversion", n, 0);
    c_done = 1'b1; @(negedge clk); c_done = 1'b0;
    check("R10 done while idle gives no irq", irq, 0);
    @(negedge clk);
    check("R10 done while idle starts nothing", samp_en, 0);

    // R8: disable in mid-conversion, fresh count afterwards
    en = 1'b0; @(negedge clk);
    auto_s = 1'b1; cc = 2'd1; lim = 4'd3; st = 5'd2; dv = 6'd1; en = 1'b1;
    @(negedge clk);
    wait_cs(n);
    do_conv(0, 2'b10, 0, "dis");
    wait_cs(n);
    check("R5 second channel converting", sel, 1);
    en = 1'b0; @(negedge clk);
    check("R8 samp_en cleared", samp_en, 0);
    check("R8 chan_sel cleared", sel, 0);
    check("R8 strobe cleared", conv_start, 0);
    en = 1'b1; @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      wait_cs(n);
      check("R8 window after re-enable", n, 4);
      do_conv(k % 2, 3 & ~(1 << (k % 2)), (k == 3) ? 1 : 0, "R8 fresh");
    end

    // R9: field change during a window applies to the next one
    en = 1'b0; @(negedge clk);
    cc = 2'd0; lim = 4'd1; st = 5'd2; dv = 6'd1; en = 1'b1;
    @(negedge clk);
    st = 5'd5;
    wait_cs(n);
    check("R9 current window keeps old length", n, 4);
    do_conv(0, 0, 0, "latch");
    wait_cs(n);
    check("R9 next window uses new length", n, 10);
    do_conv(0, 0, 1, "latch");

    finish_run();
  end
endmodule